// File: doc/BRIEF.md
# Timebase Compare Channel with Sticky Match Flag

This block is a single compare channel that watches a free-running 16-bit timebase supplied from outside. The CPU loads a 16-bit compare value one byte at a time through a small register port. While comparison is armed, the channel checks the timebase against the stored value on every clock. When they are equal it raises a sticky match flag. The flag drives an interrupt request whenever the channel's interrupt enable is set.

Arming works by byte order. Writing the low compare byte disarms comparison, and writing the high compare byte arms it again. If software loads the low byte first and the high byte last, a value that is only half updated can never cause a match. A mode register holds three enables: interrupt, match and compare. The flag stays set until software writes a zero to it.

Register map, by write or read address:

| Address | Contents |
|---------|----------|
| 0 | compare low byte |
| 1 | compare high byte |
| 2 | mode register: bit 0 interrupt enable, bit 1 match enable, bit 2 compare enable |
| 3 | status: bit 0 match flag |

Top module: `cmp_match_chan`

## Requirements
- R1: After reset, both compare bytes, all three mode bits, the flag (status bit 0) and `irq` read as 0.
- R2: A write to address 0 stores the low compare byte and forces the compare enable (mode bit 2) to 0 from the next clock.
- R3: A write to address 1 stores the high compare byte and forces the compare enable (mode bit 2) to 1 from the next clock.
- R4: When compare enable and match enable (mode bit 1) are both 1 and the timebase equals the compare value during a cycle, the flag is 1 from the following clock.
- R5: While compare enable or match enable is 0, equality between the timebase and the compare value does not set the flag.
- R6: Once set, the flag stays 1 after the timebase moves away from the compare value, and a match lasting several cycles keeps it at 1.
- R7: A write to address 3 with data bit 0 equal to 0 clears the flag from the next clock. A write to address 3 with data bit 0 equal to 1 leaves the flag unchanged.
- R8: If a match and a flag-clearing write fall in the same cycle, the flag is 1 after that clock.
- R9: `irq` is 1 exactly when the flag is 1 and the interrupt enable (mode bit 0) is 1.
- R10: After a low-byte write and before the high-byte write, the timebase equalling the partly updated compare value does not set the flag. After the high-byte write, the flag sets one clock later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| timebase | input | 16 | External free-running count |
| flag | output | 1 | Sticky match flag |
| irq | output | 1 | Interrupt request |

## Verification
A register write is visible on `rd_data` from the clock edge that samples the strobe. The flag appears one edge after the cycle in which the timebase equals the compare value. `irq` follows the flag and the interrupt enable in the same cycle, with no added delay. The bench changes inputs on falling edges and samples on the falling edge after the edge where a result is due. Where a result must not appear, it samples both before and after that edge.

// File: rtl/cmp_pkg.sv
// Package: shared constants for the compare channel.
// Assumes mode and status fields sit in the low bits of a byte register.
package cmp_pkg;
    localparam int MODE_IE = 0;   // interrupt enable bit
    localparam int MODE_ME = 1;   // match enable bit
    localparam int MODE_CE = 2;   // compare enable bit
    localparam int STAT_FLAG = 0; // match flag bit in status register

    typedef struct packed {
        logic ce;
        logic me;
        logic ie;
    } mode_t;
endpackage

// File: rtl/cmp_regs.sv
// Module: register file for the compare channel.
// Holds the compare bytes and mode bits, applies the byte-write side effects
// on compare enable, decodes a flag-clear request, and drives the read mux.
// Assumes byte addresses 0..NB-1 are compare lanes (lane 0 lowest),
// NB is the mode register and NB+1 is status.
module cmp_regs #(
    parameter int TB_W   = 16,
    parameter int BYTE_W = 8,
    localparam int NB    = TB_W / BYTE_W,
    localparam int AW    = $clog2(NB + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr,
    input  logic              flag,
    output logic [BYTE_W-1:0] rd_data,
    output logic [TB_W-1:0]   cmp_val,
    output cmp_pkg::mode_t    mode,
    output logic              clr_req
);
    import cmp_pkg::*;

    localparam logic [AW-1:0] A_LOW  = AW'(0);
    localparam logic [AW-1:0] A_HIGH = AW'(NB - 1);
    localparam logic [AW-1:0] A_MODE = AW'(NB);
    localparam logic [AW-1:0] A_STAT = AW'(NB + 1);

    logic [NB-1:0][BYTE_W-1:0] lane_q;

    // One register per compare byte lane.
    for (genvar g = 0; g < NB; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n)
                lane_q[g] <= '0;
            else if (wr_en && wr_addr == AW'(g))
                lane_q[g] <= wr_data;
        end
    end

    assign cmp_val = lane_q;

    // Mode bits: direct writes, plus compare-enable side effects of byte writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= '0;
        end else if (wr_en) begin
            if (wr_addr == A_MODE) begin
                mode.ie <= wr_data[MODE_IE];
                mode.me <= wr_data[MODE_ME];
                mode.ce <= wr_data[MODE_CE];
            end else if (wr_addr == A_LOW) begin
                mode.ce <= 1'b0;
            end else if (wr_addr == A_HIGH) begin
                mode.ce <= 1'b1;
            end
        end
    end

    // A status write with a zero in the flag bit requests a clear.
    assign clr_req = wr_en && (wr_addr == A_STAT) && !wr_data[STAT_FLAG];

    // Read multiplexer over lanes, mode and status.
    always_comb begin
        rd_data = '0;
        if (rd_addr == A_MODE) begin
            rd_data[MODE_IE] = mode.ie;
            rd_data[MODE_ME] = mode.me;
            rd_data[MODE_CE] = mode.ce;
        end else if (rd_addr == A_STAT) begin
            rd_data[STAT_FLAG] = flag;
        end else begin
            for (int i = 0; i < NB; i++)
                if (rd_addr == AW'(i))
                    rd_data = lane_q[i];
        end
    end
endmodule

// File: rtl/cmp_detect.sv
// Module: equality detector between the timebase and the compare value.
// Compares lane by lane and qualifies the result with both enables.
// Purely combinational; the flag register downstream provides the delay.
module cmp_detect #(
    parameter int TB_W   = 16,
    parameter int BYTE_W = 8,
    localparam int NB    = TB_W / BYTE_W
) (
    input  logic [TB_W-1:0] timebase,
    input  logic [TB_W-1:0] cmp_val,
    input  logic            ce,
    input  logic            me,
    output logic            hit
);
    logic [NB-1:0] lane_eq;

    // Per-lane equality.
    for (genvar g = 0; g < NB; g++) begin : g_eq
        assign lane_eq[g] = (timebase[g*BYTE_W +: BYTE_W] == cmp_val[g*BYTE_W +: BYTE_W]);
    end

    assign hit = ce && me && (&lane_eq);
endmodule

// File: rtl/cmp_flag.sv
// Module: sticky match flag and interrupt request.
// The flag is set by a hit and cleared only by a software request.
// A set has priority over a clear in the same cycle.
module cmp_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic clr_req,
    input  logic ie,
    output logic flag,
    output logic irq
);
    // Flag register: set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag <= 1'b0;
        else if (hit)
            flag <= 1'b1;
        else if (clr_req)
            flag <= 1'b0;
    end

    assign irq = flag && ie;
endmodule

// File: rtl/cmp_match_chan.sv
// Module: top of the compare channel.
// Ties the register file, the detector and the flag logic together.
// Assumes the timebase is already in this clock domain.
module cmp_match_chan #(
    parameter int TB_W   = 16,
    parameter int BYTE_W = 8,
    localparam int NB    = TB_W / BYTE_W,
    localparam int AW    = $clog2(NB + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    input  logic [TB_W-1:0]   timebase,
    output logic              flag,
    output logic              irq
);
    logic [TB_W-1:0] cmp_val;
    cmp_pkg::mode_t  mode;
    logic            clr_req;
    logic            hit;

    cmp_regs #(.TB_W(TB_W), .BYTE_W(BYTE_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .flag    (flag),
        .rd_data (rd_data),
        .cmp_val (cmp_val),
        .mode    (mode),
        .clr_req (clr_req)
    );

    cmp_detect #(.TB_W(TB_W), .BYTE_W(BYTE_W)) u_det (
        .timebase (timebase),
        .cmp_val  (cmp_val),
        .ce       (mode.ce),
        .me       (mode.me),
        .hit      (hit)
    );

    cmp_flag u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit     (hit),
        .clr_req (clr_req),
        .ie      (mode.ie),
        .flag    (flag),
        .irq     (irq)
    );
endmodule

// File: rtl/cmp_match_chk.sv
// Module: assertion checker for the compare channel, bound to the top.
module cmp_match_chk #(
    parameter int TB_W   = 16,
    parameter int BYTE_W = 8,
    localparam int NB    = TB_W / BYTE_W,
    localparam int AW    = $clog2(NB + 2)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [AW-1:0]     wr_addr,
    input logic [BYTE_W-1:0] wr_data,
    input logic [TB_W-1:0]   timebase,
    input logic [TB_W-1:0]   cmp_val,
    input logic              ce,
    input logic              me,
    input logic              ie,
    input logic              flag,
    input logic              irq
);
    a_r2_low_write_disarms: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == AW'(0)) |=> !ce);

    a_r3_high_write_arms: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == AW'(NB - 1)) |=> ce);

    a_r4_match_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && me && timebase == cmp_val) |=> flag);

    a_r5_rise_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(ce && me && timebase == cmp_val));

    a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !(wr_en && wr_addr == AW'(NB + 1) && !wr_data[0])) |=> flag);

    a_r9_irq_gating: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (flag && ie));
endmodule

bind cmp_match_chan cmp_match_chk #(.TB_W(TB_W), .BYTE_W(BYTE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .timebase (timebase),
    .cmp_val  (cmp_val),
    .ce       (mode.ce),
    .me       (mode.me),
    .ie       (mode.ie),
    .flag     (flag),
    .irq      (irq)
);

// File: tb/tb_cmp_match_chan.sv
// Bench: directed scenarios for the compare channel, one task each.
module tb_cmp_match_chan;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic [15:0] timebase = 16'hFFFF;
    logic       flag;
    logic       irq;
    int nvec = 0;
    int nerr = 0;
    bit done = 0;

    cmp_match_chan dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .timebase(timebase), .flag(flag), .irq(irq)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rd(2'd0, d); chk("R1 low byte", d, 8'h00);
        rd(2'd1, d); chk("R1 high byte", d, 8'h00);
        rd(2'd2, d); chk("R1 mode", d, 8'h00);
        rd(2'd3, d); chk("R1 status", d, 8'h00);
        chk("R1 flag", flag, 1'b0);
        chk("R1 irq", irq, 1'b0);
    endtask

    task automatic t_bytes();
        logic [7:0] d;
        wr(2'd2, 8'h06);
        wr(2'd0, 8'h34);
        rd(2'd0, d); chk("R2 low stored", d, 8'h34);
        rd(2'd2, d); chk("R2 ce cleared", d, 8'h02);
        wr(2'd1, 8'h12);
        rd(2'd1, d); chk("R3 high stored", d, 8'h12);
        rd(2'd2, d); chk("R3 ce set", d, 8'h06);
    endtask

    task automatic t_match();
        logic [7:0] d;
        timebase = 16'h1234;
        chk("R4 flag before edge", flag, 1'b0);
        @(negedge clk);
        chk("R4 flag after match", flag, 1'b1);
        @(negedge clk);
        chk("R6 held over long match", flag, 1'b1);
        timebase = 16'h0000;
        repeat (3) @(negedge clk);
        chk("R6 sticky after match", flag, 1'b1);
        chk("R9 irq masked", irq, 1'b0);
        wr(2'd2, 8'h07);
        chk("R9 irq enabled", irq, 1'b1);
        wr(2'd3, 8'h01);
        chk("R7 write one no effect", flag, 1'b1);
        wr(2'd3, 8'h00);
        chk("R7 write zero clears", flag, 1'b0);
        chk("R9 irq drops", irq, 1'b0);
        rd(2'd3, d); chk("R7 status reads 0", d, 8'h00);
    endtask

    task automatic t_disabled();
        wr(2'd2, 8'h04);
        timebase = 16'h1234;
        repeat (3) @(negedge clk);
        chk("R5 match enable off", flag, 1'b0);
        timebase = 16'h0000;
        wr(2'd2, 8'h02);
        timebase = 16'h1234;
        repeat (3) @(negedge clk);
        chk("R5 compare enable off", flag, 1'b0);
        timebase = 16'h0000;
    endtask

    task automatic t_halfwrite();
        wr(2'd2, 8'h06);
        timebase = 16'h1256;
        @(negedge clk);
        chk("R10 no match on old value", flag, 1'b0);
        wr(2'd0, 8'h56);
        repeat (3) @(negedge clk);
        chk("R10 no match when half written", flag, 1'b0);
        wr(2'd1, 8'h12);
        chk("R10 not yet on arm edge", flag, 1'b0);
        @(negedge clk);
        chk("R10 match after high write", flag, 1'b1);
        timebase = 16'h0000;
        wr(2'd3, 8'h00);
        chk("R7 cleared again", flag, 1'b0);
    endtask

    task automatic t_setwins();
        timebase = 16'h1256;
        wr(2'd3, 8'h00);
        chk("R8 set wins over clear", flag, 1'b1);
        timebase = 16'h0000;
        wr(2'd3, 8'h00);
        chk("R8 later clear works", flag, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_bytes();
        t_match();
        t_disabled();
        t_halfwrite();
        t_setwins();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            nerr++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end
endmodule